// File: doc/BRIEF.md
# Horizontal Resampling Pixel Selector

This block sits at the front of a horizontal scaler for a graphics line. It accepts input pixels over a valid/ready stream. It decides which of them produce an output pixel by stepping a fractional phase accumulator. It also hands the fractional phase of each produced pixel to a downstream interpolator. The interpolation arithmetic and the line memory live elsewhere. This block only chooses pixels and tags them with a phase.

Each line begins with a pixel that carries a start-of-line marker. The block first skips a programmed number of leading pixels, which form the horizontal offset. It then treats a programmed number of pixels as the active region and consumes anything after that region without producing output. Before scaling, each active pixel can be repeated 1, 2 or 4 times, which stands in for a faster internal pixel clock. The phase increment is the output pixel count divided by the effective input pixel count (active count times the repeat ratio), multiplied by 4096 and rounded up. An increment of zero selects unity bypass.

The configuration is checked continuously. A line too short to hold the offset, the active pixels and at least 10 blanking clocks raises an error flag. While that flag is up, input is drained and no output is produced.

Top module: `hs_phase_sel`

## Requirements
- R1: With `cfg_inc` equal to 0 (bypass), every slot of every active pixel produces one output carrying that pixel's data unchanged and an `out_phase` of 0.
- R2: With a nonzero `cfg_inc`, each slot of an active pixel adds `cfg_inc` to a 12-bit accumulator. An output carrying that pixel's data is produced exactly when the sum reaches 4096 or more, and `out_phase` is the sum minus 4096. Hence `out_phase` is always below `cfg_inc`.
- R3: Pixel indices count from 0 at the start-of-line pixel. Pixels with an index below `cfg_offset`, or at or above `cfg_offset + cfg_active`, are consumed without producing output.
- R4: `cfg_ups` code 0, 1 or 2 gives each active pixel 1, 2 or 4 slots respectively, and each slot is evaluated as in R1/R2.
- R5: `cfg_err` is 1 when `cfg_offset + cfg_active + 10 > cfg_line_len` or when `cfg_ups` is 3, and 0 otherwise. A line with exactly 10 blanking clocks is valid.
- R6: While `cfg_err` is 1, input pixels are still accepted and no output is produced.
- R7: An input pixel with `in_sol` = 1 restarts the pixel index at 0 and clears the accumulator, even if the previous line was cut short. Identical lines therefore give identical outputs.
- R8: The first output after a start-of-line pixel has `out_sol` = 1, and every other output has `out_sol` = 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds its data, phase and flag unchanged and no input is accepted. No output is lost or duplicated.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_offset | input | PIX_W | Pixels skipped after line start |
| cfg_active | input | PIX_W | Active input pixels per line |
| cfg_line_len | input | PIX_W | Total input line length in clocks |
| cfg_ups | input | 2 | Repeat ratio code: 0→1, 1→2, 2→4, 3 invalid |
| cfg_inc | input | PHASE_W | Phase increment, 0 = bypass |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when valid |
| in_data | input | DATA_W | Input pixel data |
| in_sol | input | 1 | Input pixel is the first of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | DATA_W | Selected pixel data |
| out_phase | output | PHASE_W | Fractional phase for interpolation |
| out_sol | output | 1 | First output of the line |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The bench cuts a line short and then starts a fresh one. A design that failed to clear the index or the accumulator on the marker would shift the window or the phases of the next line. Upsampling with ratios 2 and 4 is run both with bypass and with a fractional increment. A design that advanced the input after a single slot would drop outputs, and one that repeated the slots in bypass wrongly would duplicate them. The configuration check is exercised exactly at the 10-clock blanking boundary and one clock short of it, and with the invalid ratio code. An off-by-one comparison would either reject a valid line or let an invalid line emit pixels. Random output stalls confirm that a held output never changes and that no pixel is dropped across a stall.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        UPS_X1   = 2'd0,
        UPS_X2   = 2'd1,
        UPS_X4   = 2'd2,
        UPS_RSVD = 2'd3
    } ups_e;

    localparam int unsigned BLANK_MIN_DEF = 10;

    // per-slot decision passed from the region tracker to the accumulator
    typedef struct packed {
        logic live;     // slot belongs to an active pixel and config is sane
        logic last;     // final slot of the current pixel
        logic restart;  // first slot of a start-of-line pixel
    } slot_t;

    function automatic logic [1:0] ups_last_slot(input ups_e m);
        case (m)
            UPS_X2:  return 2'd1;
            UPS_X4:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/hs_cfg_check.sv
module hs_cfg_check
    import hs_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int BLANK_MIN = 10
) (
    input  logic [PIX_W-1:0] offset,
    input  logic [PIX_W-1:0] active,
    input  logic [PIX_W-1:0] line_len,
    input  ups_e             ups,
    output logic             err,
    output logic [1:0]       last_sub
);
    localparam int SUM_W = PIX_W + 2;

    logic [SUM_W-1:0] need;

    always_comb begin
        need     = SUM_W'(offset) + SUM_W'(active) + SUM_W'(BLANK_MIN);
        err      = (need > SUM_W'(line_len)) || (ups == UPS_RSVD);
        last_sub = ups_last_slot(ups);
    end

endmodule

// File: rtl/hs_region.sv
module hs_region
    import hs_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             in_sol,
    input  logic             err,
    input  logic [PIX_W-1:0] offset,
    input  logic [PIX_W-1:0] active,
    input  logic [1:0]       last_sub,
    output slot_t            slot,
    output logic             pix_done
);
    localparam int WIN_W = PIX_W + 1;

    logic [PIX_W-1:0] idx_q;
    logic [1:0]       sub_q;
    logic [PIX_W-1:0] idx_eff;
    logic [WIN_W-1:0] win_end;
    logic             in_win;

    always_comb begin
        slot.restart = in_sol && (sub_q == 2'd0);
        idx_eff      = slot.restart ? '0 : idx_q;
        win_end      = WIN_W'(offset) + WIN_W'(active);
        in_win       = (idx_eff >= offset) && (WIN_W'(idx_eff) < win_end);
        slot.live    = in_win && !err;
        slot.last    = (sub_q >= last_sub);
        pix_done     = slot.last || !slot.live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            sub_q <= '0;
        end else if (step) begin
            if (pix_done) begin
                idx_q <= (&idx_eff) ? idx_eff : idx_eff + 1'b1;
                sub_q <= '0;
            end else begin
                idx_q <= idx_eff;
                sub_q <= sub_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/hs_phase_acc.sv
module hs_phase_acc
    import hs_pkg::*;
#(
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  slot_t              slot,
    input  logic [PHASE_W-1:0] inc,
    output logic               emit,
    output logic [PHASE_W-1:0] phase,
    output logic               sol
);
    logic [PHASE_W-1:0] acc_q;
    logic               pend_q;
    logic [PHASE_W-1:0] acc_eff;
    logic               pend_eff;
    logic [PHASE_W:0]   sum;
    logic               bypass;

    always_comb begin
        acc_eff  = slot.restart ? '0 : acc_q;
        pend_eff = slot.restart ? 1'b1 : pend_q;
        sum      = {1'b0, acc_eff} + {1'b0, inc};
        bypass   = (inc == '0);
        emit     = slot.live && (bypass || sum[PHASE_W]);
        phase    = bypass ? '0 : sum[PHASE_W-1:0];
        sol      = pend_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pend_q <= 1'b1;
        end else if (step) begin
            acc_q  <= slot.live ? sum[PHASE_W-1:0] : acc_eff;
            pend_q <= emit ? 1'b0 : pend_eff;
        end
    end

endmodule

// File: rtl/hs_phase_sel.sv
module hs_phase_sel
    import hs_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int DATA_W    = 24,
    parameter int PHASE_W   = 12,
    parameter int BLANK_MIN = BLANK_MIN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PIX_W-1:0]   cfg_offset,
    input  logic [PIX_W-1:0]   cfg_active,
    input  logic [PIX_W-1:0]   cfg_line_len,
    input  logic [1:0]         cfg_ups,
    input  logic [PHASE_W-1:0] cfg_inc,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic [PHASE_W-1:0] out_phase,
    output logic               out_sol,
    output logic               cfg_err
);
    logic               err;
    logic [1:0]         last_sub;
    slot_t              slot;
    logic               pix_done;
    logic               room;
    logic               step;
    logic               emit;
    logic [PHASE_W-1:0] phase;
    logic               sol_flag;

    hs_cfg_check #(.PIX_W(PIX_W), .BLANK_MIN(BLANK_MIN)) u_cfg (
        .offset   (cfg_offset),
        .active   (cfg_active),
        .line_len (cfg_line_len),
        .ups      (ups_e'(cfg_ups)),
        .err      (err),
        .last_sub (last_sub)
    );

    hs_region #(.PIX_W(PIX_W)) u_region (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .in_sol   (in_sol),
        .err      (err),
        .offset   (cfg_offset),
        .active   (cfg_active),
        .last_sub (last_sub),
        .slot     (slot),
        .pix_done (pix_done)
    );

    hs_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .slot  (slot),
        .inc   (cfg_inc),
        .emit  (emit),
        .phase (phase),
        .sol   (sol_flag)
    );

    always_comb begin
        room     = !out_valid || out_ready;
        step     = in_valid && room;
        in_ready = room && pix_done;
        cfg_err  = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_phase <= '0;
            out_sol   <= 1'b0;
        end else if (room) begin
            out_valid <= step && emit;
            if (step && emit) begin
                out_data  <= in_data;
                out_phase <= phase;
                out_sol   <= sol_flag;
            end
        end
    end

endmodule

// File: rtl/hs_phase_sel_chk.sv
module hs_phase_sel_chk #(
    parameter int PIX_W     = 12,
    parameter int DATA_W    = 24,
    parameter int PHASE_W   = 12,
    parameter int BLANK_MIN = 10
) (
    input logic               clk,
    input logic               rst,
    input logic [PIX_W-1:0]   cfg_offset,
    input logic [PIX_W-1:0]   cfg_active,
    input logic [PIX_W-1:0]   cfg_line_len,
    input logic [1:0]         cfg_ups,
    input logic [PHASE_W-1:0] cfg_inc,
    input logic               in_valid,
    input logic               in_ready,
    input logic [DATA_W-1:0]  in_data,
    input logic               in_sol,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DATA_W-1:0]  out_data,
    input logic [PHASE_W-1:0] out_phase,
    input logic               out_sol,
    input logic               cfg_err
);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_phase) && $stable(out_sol));

    p_no_take_stalled_r9: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!out_valid || out_ready));

    p_bypass_phase_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid && (cfg_inc == '0) |-> (out_phase == '0));

    p_phase_below_inc_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && (cfg_inc != '0) |-> (out_phase < cfg_inc));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_err && !out_valid |=> (!out_valid || !$past(cfg_err)));

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

bind hs_phase_sel hs_phase_sel_chk #(
    .PIX_W(PIX_W), .DATA_W(DATA_W), .PHASE_W(PHASE_W), .BLANK_MIN(BLANK_MIN)
) u_chk (.*);

// File: tb/hs_phase_sel_tb_top.sv
module hs_phase_sel_tb_top;
    localparam int PIX_W   = 12;
    localparam int DATA_W  = 24;
    localparam int PHASE_W = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [PIX_W-1:0]   cfg_offset = '0;
    logic [PIX_W-1:0]   cfg_active = '0;
    logic [PIX_W-1:0]   cfg_line_len = 12'd100;
    logic [1:0]         cfg_ups = '0;
    logic [PHASE_W-1:0] cfg_inc = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [DATA_W-1:0]  in_data = '0;
    logic               in_sol = 1'b0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [DATA_W-1:0]  out_data;
    logic [PHASE_W-1:0] out_phase;
    logic               out_sol;
    logic               cfg_err;

    always #5 clk = ~clk;

    hs_phase_sel dut_i (.*);

    typedef struct {
        logic [DATA_W-1:0]  d;
        logic [PHASE_W-1:0] ph;
        logic               sol;
        string              tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // random downstream stalls
    initial begin
        forever begin
            @(posedge clk);
            #1 out_ready = (($urandom % 10) < 7);
        end
    end

    // monitor: hold check and scoreboard
    bit                 hold_pend = 0;
    logic [DATA_W-1:0]  hd;
    logic [PHASE_W-1:0] hp;
    logic               hs;
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend)
                chk(out_valid && out_data == hd && out_phase == hp && out_sol == hs,
                    "R9", "stalled output changed", longint'(out_data), longint'(hd));
            hold_pend = out_valid && !out_ready;
            hd = out_data; hp = out_phase; hs = out_sol;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 R6", "unexpected output", longint'(out_data), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_data == e.d, e.tag, "data", longint'(out_data), longint'(e.d));
                    chk(out_phase == e.ph, e.tag, "phase", longint'(out_phase), longint'(e.ph));
                    chk(out_sol == e.sol, "R8", "sol flag", longint'(out_sol), longint'(e.sol));
                end
            end
        end
    end

    task automatic run_line(input int off, input int act, input int len, input int ups,
                            input int inc, input int npix, input int line_no);
        int  r;
        int  acc;
        bit  first;
        bit  err;
        string t;
        r     = 1 << ups;
        acc   = 0;
        first = 1;
        err   = (off + act + 10 > len) || (ups == 3);
        t     = (inc == 0) ? "R1" : "R2";
        if (ups != 0) t = {t, " R4"};
        cfg_offset   = PIX_W'(off);
        cfg_active   = PIX_W'(act);
        cfg_line_len = PIX_W'(len);
        cfg_ups      = 2'(ups);
        cfg_inc      = PHASE_W'(inc);
        #1;
        chk(cfg_err == err, "R5", "config error flag", longint'(cfg_err), longint'(err));
        for (int i = 0; i < npix; i++) begin
            if (!err && i >= off && i < off + act) begin
                for (int s = 0; s < r; s++) begin
                    exp_t e;
                    e.d   = DATA_W'((line_no << 16) | i);
                    e.tag = t;
                    if (inc == 0) begin
                        e.ph = '0; e.sol = first; first = 0;
                        exp_q.push_back(e);
                    end else begin
                        acc += inc;
                        if (acc >= 4096) begin
                            acc -= 4096;
                            e.ph = PHASE_W'(acc); e.sol = first; first = 0;
                            exp_q.push_back(e);
                        end
                    end
                end
            end
        end
        @(posedge clk); #1;
        for (int i = 0; i < npix; i++) begin
            in_valid = 1'b1;
            in_sol   = (i == 0);
            in_data  = DATA_W'((line_no << 16) | i);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, err ? "R6" : "R3 R7", "outputs missing at line end",
            longint'(exp_q.size()), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
        chk(cfg_err == 1'b0, "R5", "cfg_err with valid config", longint'(cfg_err), 0);
        // bypass, window skip
        run_line(3, 8, 24, 0, 0, 24, 1);
        // downscale 16/20
        run_line(4, 20, 40, 0, 3277, 40, 2);
        // identical line: no phase carry-over (R7)
        run_line(4, 20, 40, 0, 3277, 40, 3);
        // cut-short line then full line (R7)
        run_line(4, 20, 40, 0, 3277, 10, 4);
        run_line(4, 20, 40, 0, 3277, 40, 5);
        // ratio 2 with increment (R4)
        run_line(2, 10, 30, 1, 3072, 30, 6);
        // ratio 4 bypass (R4)
        run_line(1, 5, 20, 2, 0, 20, 7);
        // ratio 4 with increment (R4)
        run_line(0, 6, 20, 2, 2219, 20, 8);
        // near-maximum increment
        run_line(2, 12, 30, 0, 4095, 30, 9);
        // exactly 10 blanking clocks: valid (R5)
        run_line(5, 20, 35, 0, 0, 35, 10);
        // one clock short: error, no output (R5, R6)
        run_line(5, 20, 34, 0, 0, 34, 11);
        // reserved ratio code (R5, R6)
        run_line(0, 8, 30, 3, 0, 30, 12);
        // recovery after error
        run_line(0, 8, 30, 1, 0, 30, 13);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", "run did not complete", 0, 1);
            summary();
            $finish;
        end
    end

endmodule